// File: doc/BRIEF.md
# Decimal-Capable Accumulator ALU

A purely combinational arithmetic unit for a small accumulator machine. It takes an accumulator value and a memory value, a carry input, a decimal-enable bit and a two-bit operation code. It produces a result, the negative, overflow, zero and carry flags, and a write-enable mask for those flags. The four operations are add with carry, subtract with borrow, exclusive OR and a one-place logical right shift of the accumulator operand.

With decimal mode on, the two arithmetic operations treat every 4-bit group of each operand as one decimal digit, 0 to 9. The result comes back as packed decimal.

A build parameter chooses how the flags behave during decimal arithmetic:
- **Legacy behaviour:** negative, overflow and zero describe the uncorrected binary sum. Only carry follows the decimal answer.
- **Corrected behaviour:** every flag describes the decimal answer. The unit also raises a request for one extra cycle so the surrounding sequencer can stretch the instruction.

Top module: `bcd_alu`

## Requirements
- R1: With opSel = 2'b00 and decMode = 0, result is (opA + opM + carryIn) mod 256 and flagC is bit 8 of that sum. flagN is result bit 7, flagZ is 1 exactly when result is zero, and flagWe = 4'b1111. The flagWe bits are, from bit 3 down to bit 0: N, V, Z, C.
- R2: With opSel = 2'b01 and decMode = 0, result is (opA + ~opM + carryIn) mod 256, which equals opA - opM - (1 - carryIn). flagC is 1 when no borrow occurred, and flagN, flagZ and flagWe follow R1.
- R3: In binary arithmetic, flagV is 1 exactly when opA bit 7 equals bit 7 of the effective second operand (opM for add, ~opM for subtract) and result bit 7 differs from it.
- R4: With opSel = 2'b00, decMode = 1 and both operands valid packed decimal, result is the packed decimal form of (a + m + carryIn) mod 100, and flagC is 1 when that sum reaches 100.
- R5: With opSel = 2'b01, decMode = 1 and both operands valid packed decimal, result is the packed decimal form of (a - m - (1 - carryIn)) mod 100, and flagC is 1 when that difference is not negative.
- R6: With CORRECTED_FLAGS = 0 and decimal arithmetic, flagN, flagZ and flagV are taken from the binary sum of R1/R2 (for flagV, as in R3), while flagC follows R4/R5.
- R7: With CORRECTED_FLAGS = 1 and decimal arithmetic, flagN and flagZ describe the decimal result. flagV is the R3 rule applied to the decimal result.
- R8: extraCycle is 1 exactly when CORRECTED_FLAGS = 1, decMode = 1 and opSel is 2'b00 or 2'b01.
- R9: With opSel = 2'b10, result is opA XOR opM, flagN and flagZ describe it, and flagWe = 4'b1010 so V and C are left untouched.
- R10: With opSel = 2'b11, result is opA shifted right one place with 0 entering bit 7. flagC is opA bit 0, flagN is 0, flagZ describes the result, and flagWe = 4'b1011.
- R11: decMode has no effect on the result, the flag outputs, flagWe or extraCycle when opSel is 2'b10 or 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | Accumulator operand |
| opM | input | WIDTH | Memory operand |
| carryIn | input | 1 | Carry in; inverted borrow for subtraction |
| decMode | input | 1 | Packed decimal arithmetic enable |
| opSel | input | 2 | 00 add, 01 subtract, 10 XOR, 11 shift right |
| result | output | WIDTH | Operation result |
| flagN | output | 1 | Negative flag value |
| flagV | output | 1 | Overflow flag value |
| flagZ | output | 1 | Zero flag value |
| flagC | output | 1 | Carry flag value |
| flagWe | output | 4 | Flag write enables {N,V,Z,C} |
| extraCycle | output | 1 | Request for one added cycle |

## Verification
The bench sweeps every operand pair and both carry values in binary mode, and every valid decimal pair in both decimal directions. It targets these corner cases:
- **Digit wrap:** 9+1 and 0-1 digit wraps and the 99+1 and 0-0-borrow wraparounds. A wrong correction constant or a lost inter-digit carry shows up as non-decimal digits or an off-by-ten answer.
- **Legacy versus corrected flags:** both flag variants are compared on the same decimal inputs. Taking flags from the wrong sum makes zero or negative disagree, for example 50+50 in legacy mode gives a nonzero binary sum but a zero decimal result.
- **Decimal bit leaking into logic operations:** the bench repeats XOR and shift with the decimal bit set. A leaking mode bit would corrupt those results or raise a spurious extra-cycle request.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_XOR = 2'b10,
    OP_SHR = 2'b11
  } aluOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic doSub;
    logic doXor;
    logic doShift;
    logic bcdActive;
    logic useCorrected;
  } aluCtl_t;

endpackage

// File: rtl/bcd_alu_ctrl.sv
module bcd_alu_ctrl
  import bcd_alu_pkg::*;
#(
  parameter bit CORRECTED_FLAGS = 1'b0
) (
  input  logic [1:0] opSel,
  input  logic       decMode,
  output aluCtl_t    ctl,
  output logic [3:0] flagWe,
  output logic       extraCycle
);

  logic isArith;

  always_comb begin
    isArith          = (opSel == OP_ADD) || (opSel == OP_SUB);
    ctl.doSub        = (opSel == OP_SUB);
    ctl.doXor        = (opSel == OP_XOR);
    ctl.doShift      = (opSel == OP_SHR);
    ctl.bcdActive    = isArith && decMode;
    ctl.useCorrected = CORRECTED_FLAGS;
    unique case (opSel)
      OP_XOR:  flagWe = 4'b1010;
      OP_SHR:  flagWe = 4'b1011;
      default: flagWe = 4'b1111;
    endcase
    extraCycle = CORRECTED_FLAGS && isArith && decMode;

    // R8: an extra cycle is only ever requested for decimal arithmetic
    a_r8_extra_scope: assert (!extraCycle || (decMode && !opSel[1]))
      else $error("extra cycle outside decimal arithmetic");
  end

endmodule

// File: rtl/bcd_alu_dp.sv
module bcd_alu_dp
  import bcd_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  aluCtl_t          ctl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opM,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             flagN,
  output logic             flagV,
  output logic             flagZ,
  output logic             flagC
);

  localparam int DIGITS = WIDTH / 4;
  localparam int MSB    = WIDTH - 1;

  logic [WIDTH-1:0] mEff;
  logic [WIDTH:0]   binSum;
  logic             binV;
  logic [WIDTH-1:0] bcdRes;
  logic             bcdCarry;

  // digit-serial decimal chain; carry or borrow ripples between digits
  always_comb begin : decChain
    logic       link;
    logic [4:0] t;
    logic [4:0] a5;
    logic [4:0] m5;
    link   = ctl.doSub ? ~carryIn : carryIn;
    bcdRes = '0;
    for (int d = 0; d < DIGITS; d++) begin
      a5 = {1'b0, opA[d*4 +: 4]};
      m5 = {1'b0, opM[d*4 +: 4]};
      if (!ctl.doSub) begin
        t = a5 + m5 + {4'b0, link};
        if (t > 5'd9) begin
          t    = t + 5'd6;
          link = 1'b1;
        end else begin
          link = 1'b0;
        end
        bcdRes[d*4 +: 4] = t[3:0];
      end else begin
        t = a5 - m5 - {4'b0, link};
        if (t[4]) begin
          bcdRes[d*4 +: 4] = t[3:0] - 4'd6;
          link = 1'b1;
        end else begin
          bcdRes[d*4 +: 4] = t[3:0];
          link = 1'b0;
        end
      end
    end
    bcdCarry = ctl.doSub ? ~link : link;
  end

  always_comb begin : mainPath
    logic inBcd;
    logic outBcd;
    mEff   = ctl.doSub ? ~opM : opM;
    binSum = {1'b0, opA} + {1'b0, mEff} + {{WIDTH{1'b0}}, carryIn};
    binV   = (opA[MSB] == mEff[MSB]) && (binSum[MSB] != opA[MSB]);

    if (ctl.doShift) begin
      result = {1'b0, opA[MSB:1]};
      flagC  = opA[0];
      flagN  = 1'b0;
      flagV  = 1'b0;
    end else if (ctl.doXor) begin
      result = opA ^ opM;
      flagC  = 1'b0;
      flagN  = result[MSB];
      flagV  = 1'b0;
    end else if (ctl.bcdActive) begin
      result = bcdRes;
      flagC  = bcdCarry;
      if (ctl.useCorrected) begin
        flagN = result[MSB];
        flagV = (opA[MSB] == mEff[MSB]) && (result[MSB] != opA[MSB]);
      end else begin
        flagN = binSum[MSB];
        flagV = binV;
      end
    end else begin
      result = binSum[MSB:0];
      flagC  = binSum[WIDTH];
      flagN  = result[MSB];
      flagV  = binV;
    end
    if (ctl.bcdActive && !ctl.useCorrected) flagZ = (binSum[MSB:0] == '0);
    else                                   flagZ = (result == '0);

    inBcd  = 1'b1;
    outBcd = 1'b1;
    for (int d = 0; d < DIGITS; d++) begin
      if (opA[d*4 +: 4] > 4'd9 || opM[d*4 +: 4] > 4'd9) inBcd = 1'b0;
      if (result[d*4 +: 4] > 4'd9) outBcd = 1'b0;
    end

    // R4 and R5: valid decimal inputs always give valid decimal digits
    a_r4_bcd_digits: assert (!(ctl.bcdActive && inBcd) || outBcd)
      else $error("decimal result digit above nine");
    // R7: corrected mode zero flag tracks the decimal result
    a_r7_corr_zero: assert (!(ctl.bcdActive && ctl.useCorrected) || (flagZ == (result == '0)))
      else $error("corrected zero flag mismatch");
    // R10: shift clears the sign and moves bit 0 to carry
    a_r10_shift_flags: assert (!ctl.doShift || (!flagN && !result[MSB] && flagC == opA[0]))
      else $error("shift flags wrong");
  end

endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
  import bcd_alu_pkg::*;
#(
  parameter int WIDTH           = 8,
  parameter bit CORRECTED_FLAGS = 1'b0
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opM,
  input  logic             carryIn,
  input  logic             decMode,
  input  logic [1:0]       opSel,
  output logic [WIDTH-1:0] result,
  output logic             flagN,
  output logic             flagV,
  output logic             flagZ,
  output logic             flagC,
  output logic [3:0]       flagWe,
  output logic             extraCycle
);

  aluCtl_t ctl;

  bcd_alu_ctrl #(.CORRECTED_FLAGS(CORRECTED_FLAGS)) uCtrl (
    .opSel      (opSel),
    .decMode    (decMode),
    .ctl        (ctl),
    .flagWe     (flagWe),
    .extraCycle (extraCycle)
  );

  bcd_alu_dp #(.WIDTH(WIDTH)) uDp (
    .ctl     (ctl),
    .opA     (opA),
    .opM     (opM),
    .carryIn (carryIn),
    .result  (result),
    .flagN   (flagN),
    .flagV   (flagV),
    .flagZ   (flagZ),
    .flagC   (flagC)
  );

endmodule

// File: tb/bcd_alu_test.sv
module bcd_alu_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] opA, opM;
  logic       carryIn, decMode;
  logic [1:0] opSel;
  logic [7:0] resL, resC;
  logic       nL, vL, zL, cL, nC, vC, zC, cC, exL, exC;
  logic [3:0] weL, weC;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  bcd_alu #(.WIDTH(8), .CORRECTED_FLAGS(1'b0)) uut (
    .opA(opA), .opM(opM), .carryIn(carryIn), .decMode(decMode), .opSel(opSel),
    .result(resL), .flagN(nL), .flagV(vL), .flagZ(zL), .flagC(cL),
    .flagWe(weL), .extraCycle(exL));

  bcd_alu #(.WIDTH(8), .CORRECTED_FLAGS(1'b1)) uutFix (
    .opA(opA), .opM(opM), .carryIn(carryIn), .decMode(decMode), .opSel(opSel),
    .result(resC), .flagN(nC), .flagV(vC), .flagZ(zC), .flagC(cC),
    .flagWe(weC), .extraCycle(exC));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s A=%02h M=%02h c=%0d d=%0d op=%0d actual=%0h expected=%0h",
               tag, opA, opM, carryIn, decMode, opSel, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] op, input int a, input int m, input int c, input int d);
    opSel = op; opA = 8'(a); opM = 8'(m); carryIn = 1'(c); decMode = 1'(d);
    #1;
  endtask

  function automatic int toBcd(input int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int ovf(input int a, input int mEff, input int r);
    return (((a >> 7) & 1) == ((mEff >> 7) & 1)) && (((r >> 7) & 1) != ((a >> 7) & 1));
  endfunction

  task automatic testBinary(input bit sub);
    for (int a = 0; a < 256; a++)
      for (int m = 0; m < 256; m++)
        for (int c = 0; c < 2; c++) begin
          int me, s, r;
          me = sub ? (~m & 8'hFF) : m;
          s  = a + me + c;
          r  = s & 8'hFF;
          apply(sub ? 2'b01 : 2'b00, a, m, c, 0);
          chk(sub ? "R2 result" : "R1 result", resL, r);
          chk(sub ? "R2 carry" : "R1 carry", cL, (s >> 8) & 1);
          chk("R1 negative", nL, (r >> 7) & 1);
          chk("R1 zero", zL, r == 0);
          chk("R3 overflow", vL, ovf(a, me, r));
          chk("R1 write enables", weL, 4'b1111);
          chk("R8 no extra cycle in binary", exC, 0);
          chk("R1 corrected build agrees", {resC, nC, vC, zC, cC}, {resL, nL, vL, zL, cL});
        end
  endtask

  task automatic testDecimal(input bit sub);
    for (int a = 0; a < 100; a++)
      for (int m = 0; m < 100; m++)
        for (int c = 0; c < 2; c++) begin
          int ab, mb, me, bin, dv, r, carry;
          ab = toBcd(a); mb = toBcd(m);
          me = sub ? (~mb & 8'hFF) : mb;
          bin = (ab + me + c) & 8'hFF;
          if (sub) begin
            dv = a - m - (1 - c);
            carry = dv >= 0;
            r = toBcd((dv + 100) % 100);
          end else begin
            dv = a + m + c;
            carry = dv >= 100;
            r = toBcd(dv % 100);
          end
          apply(sub ? 2'b01 : 2'b00, ab, mb, c, 1);
          chk(sub ? "R5 result" : "R4 result", resL, r);
          chk(sub ? "R5 carry" : "R4 carry", cL, carry);
          chk("R6 legacy negative", nL, (bin >> 7) & 1);
          chk("R6 legacy zero", zL, bin == 0);
          chk("R6 legacy overflow", vL, ovf(ab, me, bin));
          chk("R8 legacy no extra", exL, 0);
          chk("R7 corrected result", resC, r);
          chk("R7 corrected carry", cC, carry);
          chk("R7 corrected negative", nC, (r >> 7) & 1);
          chk("R7 corrected zero", zC, r == 0);
          chk("R7 corrected overflow", vC, ovf(ab, me, r));
          chk("R8 extra cycle", exC, 1);
        end
  endtask

  task automatic testXor();
    for (int a = 0; a < 256; a++)
      for (int d = 0; d < 2; d++) begin
        int m, r;
        m = (a * 37 + 11) & 8'hFF;
        r = a ^ m;
        apply(2'b10, a, m, d, d);
        chk("R9 result", resL, r);
        chk("R9 negative", nL, (r >> 7) & 1);
        chk("R9 zero", zL, r == 0);
        chk("R9 write enables", weL, 4'b1010);
        chk("R11 decimal ignored by XOR", {resC, nC, zC, weC}, {8'(r), 1'((r >> 7) & 1), 1'(r == 0), 4'b1010});
        chk("R11 no extra on XOR", exC, 0);
      end
    apply(2'b10, 8'h5A, 8'h5A, 0, 1);
    chk("R9 equal operands zero", zL, 1);
  endtask

  task automatic testShift();
    for (int a = 0; a < 256; a++)
      for (int d = 0; d < 2; d++) begin
        int r;
        r = a >> 1;
        apply(2'b11, a, 8'hFF - a, 1 - d, d);
        chk("R10 result", resL, r);
        chk("R10 carry", cL, a & 1);
        chk("R10 negative", nL, 0);
        chk("R10 zero", zL, r == 0);
        chk("R10 write enables", weL, 4'b1011);
        chk("R11 decimal ignored by shift", {resC, cC, nC, zC, weC}, {8'(r), 1'(a & 1), 1'b0, 1'(r == 0), 4'b1011});
        chk("R11 no extra on shift", exC, 0);
      end
  endtask

  task automatic testCorners();
    apply(2'b00, 8'h99, 8'h01, 0, 1);
    chk("R4 99+1 wraps", resC, 8'h00);
    chk("R4 99+1 carry", cC, 1);
    apply(2'b00, 8'h50, 8'h50, 0, 1);
    chk("R6 legacy zero uses binary", zL, 0);
    chk("R7 corrected zero", zC, 1);
    apply(2'b01, 8'h00, 8'h00, 0, 1);
    chk("R5 0-0-borrow", resC, 8'h99);
    chk("R5 borrow out", cC, 0);
  endtask

  initial begin
    opA = '0; opM = '0; carryIn = 1'b0; decMode = 1'b0; opSel = 2'b00;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle add of zeros", resL, 0);
    chk("R8 idle no extra", exC, 0);
    testCorners();
    testXor();
    testShift();
    testDecimal(1'b0);
    testDecimal(1'b1);
    testBinary(1'b0);
    testBinary(1'b1);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 180000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<180000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule